// File: doc/BRIEF.md
# DLL Lock-and-Force Sequencer

This block brings up the delay-locked loop of a DRAM PHY. It produces two 32-bit control words. A start pulse loads the mandatory initial value into the main control word and a phase-shift setting into the auxiliary word. The sequencer then enables the loop. In a later, separate step it starts the loop. It then watches a status bus until the lock indication appears.

On lock, the coarse lock code from the status bus is merged into the upper byte of the main control word. This freezes the delay, and a sticky `locked` flag rises. If lock does not arrive within a programmable number of cycles, a sticky error flag rises instead. Either outcome holds until reset.

Top module: `dll_lock_seq`

## Requirements
- R1: While reset is held and after its release, `phyCtl0` and `phyCtl1` read zero, and `locked` and `timeoutErr` are low.
- R2: A `start` pulse seen while idle loads `phyCtl0` with 0x00101000 on that clock edge. On the same edge `phyCtl1` is loaded with 0x85 when `phaseSel` is 0 (90 degree shift, refresh count 8) or with 0x86 when `phaseSel` is 1 (180 degree shift, refresh count 8).
- R3: On the next edge bit 1 (loop on) of `phyCtl0` is set. On the edge after that, bit 0 (loop start) is set. Each update stays for at least one full cycle, and no bit of `phyCtl0` clears before reset.
- R4: Lock is recognised only when `dllStatus[2:0]` is 3'b111 during the wait phase.
- R5: On the edge where lock is recognised, `dllStatus[13:6]` is OR-ed into `phyCtl0[31:24]`, and `locked` rises on that same edge.
- R6: Lock is sampled on at most `timeoutLimit`+1 wait cycles. If it is absent on all of them, `timeoutErr` rises on the edge of the last one. Lock present on that last cycle wins over the timeout.
- R7: `locked` and `timeoutErr` stay high until reset, they are never high together, and status changes after the outcome leave `phyCtl0` unchanged.
- R8: `start` is ignored while the sequence runs and after it has finished.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin the bring-up sequence |
| phaseSel | input | 1 | Phase shift choice: 0 = 90 degrees, 1 = 180 degrees |
| timeoutLimit | input | 16 | Extra wait cycles allowed before timeout |
| dllStatus | input | 14 | Loop status: [2:0] lock flags, [13:6] coarse lock code |
| phyCtl0 | output | 32 | Main PHY loop control word |
| phyCtl1 | output | 32 | Auxiliary PHY control word (phase, refresh count) |
| locked | output | 1 | Lock value forced, sticky until reset |
| timeoutErr | output | 1 | Lock not seen in time, sticky until reset |

## Verification
Lock detection and timeout expiry can fall in the same cycle: lock is present on exactly the last sampled wait cycle. The bench provokes this with directed runs where the lock delay equals the limit, including a limit of zero, and with random runs around that point. It expects `locked` high with the forced code in place and `timeoutErr` low. One cycle later the opposite case, a lock that arrives one cycle too late, must give the error with `phyCtl0` left at its started value.

// File: rtl/dll_seq_pkg.sv
package dll_seq_pkg;
  typedef struct packed {
    logic loadInit;
    logic setOn;
    logic setStart;
    logic forceLock;
    logic cntClr;
    logic cntInc;
  } seqStrobe_t;

  typedef enum logic [2:0] {
    S_IDLE, S_ON, S_START, S_WAIT, S_DONE, S_FAIL
  } seqState_t;

  localparam logic [31:0] CTL0_INIT     = 32'h0010_1000;
  localparam logic [7:0]  CTL1_SHIFT90  = 8'h85;
  localparam logic [7:0]  CTL1_SHIFT180 = 8'h86;
endpackage

// File: rtl/dll_seq_ctrl.sv
module dll_seq_ctrl
  import dll_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       lockSeen,
  input  logic       cntAtLimit,
  output seqStrobe_t strobe,
  output logic       locked,
  output logic       timeoutErr
);
  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strobe    = '0;
    nextState = state;
    case (state)
      S_IDLE:  if (start) begin
                 strobe.loadInit = 1'b1;
                 nextState       = S_ON;
               end
      S_ON:    begin
                 strobe.setOn = 1'b1;
                 nextState    = S_START;
               end
      S_START: begin
                 strobe.setStart = 1'b1;
                 strobe.cntClr   = 1'b1;
                 nextState       = S_WAIT;
               end
      S_WAIT:  if (lockSeen) begin
                 strobe.forceLock = 1'b1;
                 nextState        = S_DONE;
               end else if (cntAtLimit) begin
                 nextState = S_FAIL;
               end else begin
                 strobe.cntInc = 1'b1;
               end
      default: nextState = state;
    endcase
  end

  assign locked     = (state == S_DONE);
  assign timeoutErr = (state == S_FAIL);
endmodule

// File: rtl/dll_seq_dp.sv
module dll_seq_dp
  import dll_seq_pkg::*;
#(
  parameter int CTL_W     = 32,
  parameter int TO_W      = 16,
  parameter int LOCK_BITS = 3,
  parameter int LV_LSB    = 6,
  parameter int LV_W      = 8,
  parameter int FORCE_LSB = 24,
  parameter int STAT_W    = LV_LSB + LV_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              phaseSel,
  input  logic [TO_W-1:0]   timeoutLimit,
  input  logic [STAT_W-1:0] dllStatus,
  output logic              lockSeen,
  output logic              cntAtLimit,
  output logic [CTL_W-1:0]  phyCtl0,
  output logic [CTL_W-1:0]  phyCtl1
);
  localparam logic [CTL_W-1:0] ON_BIT    = CTL_W'(2);
  localparam logic [CTL_W-1:0] START_BIT = CTL_W'(1);

  logic [TO_W-1:0]  waitCnt;
  logic [CTL_W-1:0] forceWord;
  logic [CTL_W-1:0] phaseWord;

  generate
    if (LV_LSB > LOCK_BITS) begin : g_gap
      logic unusedGap;
      assign unusedGap = ^dllStatus[LV_LSB-1:LOCK_BITS];
    end
  endgenerate

  assign lockSeen   = &dllStatus[LOCK_BITS-1:0];
  assign cntAtLimit = (waitCnt == timeoutLimit);
  assign forceWord  = CTL_W'(dllStatus[LV_LSB +: LV_W]) << FORCE_LSB;
  assign phaseWord  = CTL_W'(phaseSel ? CTL1_SHIFT180 : CTL1_SHIFT90);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phyCtl0 <= '0;
      phyCtl1 <= '0;
      waitCnt <= '0;
    end else begin
      if (strobe.loadInit) begin
        phyCtl0 <= CTL_W'(CTL0_INIT);
        phyCtl1 <= phaseWord;
      end
      if (strobe.setOn)     phyCtl0 <= phyCtl0 | ON_BIT;
      if (strobe.setStart)  phyCtl0 <= phyCtl0 | START_BIT;
      if (strobe.forceLock) phyCtl0 <= phyCtl0 | forceWord;
      if (strobe.cntClr)      waitCnt <= '0;
      else if (strobe.cntInc) waitCnt <= waitCnt + 1'b1;
    end
  end
endmodule

// File: rtl/dll_lock_seq.sv
module dll_lock_seq
  import dll_seq_pkg::*;
#(
  parameter int CTL_W     = 32,
  parameter int TO_W      = 16,
  parameter int LOCK_BITS = 3,
  parameter int LV_LSB    = 6,
  parameter int LV_W      = 8,
  parameter int FORCE_LSB = 24,
  parameter int STAT_W    = LV_LSB + LV_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              phaseSel,
  input  logic [TO_W-1:0]   timeoutLimit,
  input  logic [STAT_W-1:0] dllStatus,
  output logic [CTL_W-1:0]  phyCtl0,
  output logic [CTL_W-1:0]  phyCtl1,
  output logic              locked,
  output logic              timeoutErr
);
  seqStrobe_t strobe;
  logic       lockSeen;
  logic       cntAtLimit;

  dll_seq_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .lockSeen   (lockSeen),
    .cntAtLimit (cntAtLimit),
    .strobe     (strobe),
    .locked     (locked),
    .timeoutErr (timeoutErr)
  );

  dll_seq_dp #(
    .CTL_W(CTL_W), .TO_W(TO_W), .LOCK_BITS(LOCK_BITS),
    .LV_LSB(LV_LSB), .LV_W(LV_W), .FORCE_LSB(FORCE_LSB), .STAT_W(STAT_W)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .phaseSel     (phaseSel),
    .timeoutLimit (timeoutLimit),
    .dllStatus    (dllStatus),
    .lockSeen     (lockSeen),
    .cntAtLimit   (cntAtLimit),
    .phyCtl0      (phyCtl0),
    .phyCtl1      (phyCtl1)
  );
endmodule

// File: rtl/dll_seq_chk.sv
module dll_seq_chk #(
  parameter int CTL_W     = 32,
  parameter int LOCK_BITS = 3,
  parameter int LV_LSB    = 6,
  parameter int LV_W      = 8,
  parameter int FORCE_LSB = 24,
  parameter int STAT_W    = LV_LSB + LV_W
) (
  input logic              clk,
  input logic              rstN,
  input logic [STAT_W-1:0] dllStatus,
  input logic [CTL_W-1:0]  phyCtl0,
  input logic              locked,
  input logic              timeoutErr
);
  AST_CTL_NO_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (phyCtl0 & $past(phyCtl0)) == $past(phyCtl0)); // R3

  AST_START_AFTER_ON: assert property (@(posedge clk) disable iff (!rstN)
    $rose(phyCtl0[0]) |-> $past(phyCtl0[1])); // R3

  AST_LOCK_NEEDS_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> ($past(dllStatus[LOCK_BITS-1:0]) == {LOCK_BITS{1'b1}})); // R4

  AST_FORCE_CODE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> (phyCtl0[FORCE_LSB +: LV_W] == $past(dllStatus[LV_LSB +: LV_W]))); // R5

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> locked); // R7

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |=> timeoutErr); // R7

  AST_OUTCOME_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(locked && timeoutErr)); // R7

  AST_FROZEN_AFTER: assert property (@(posedge clk) disable iff (!rstN)
    (locked || timeoutErr) |=> $stable(phyCtl0)); // R7
endmodule

bind dll_lock_seq dll_seq_chk #(
  .CTL_W(CTL_W), .LOCK_BITS(LOCK_BITS), .LV_LSB(LV_LSB),
  .LV_W(LV_W), .FORCE_LSB(FORCE_LSB), .STAT_W(STAT_W)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .dllStatus  (dllStatus),
  .phyCtl0    (phyCtl0),
  .locked     (locked),
  .timeoutErr (timeoutErr)
);

// File: tb/dll_lock_seq_tb.sv
module dll_lock_seq_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        phaseSel = 1'b0;
  logic [15:0] timeoutLimit = '0;
  logic [13:0] dllStatus = '0;
  logic [31:0] phyCtl0, phyCtl1;
  logic        locked, timeoutErr;

  int testCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dll_lock_seq dut_i (
    .clk(clk), .rstN(rstN), .start(start), .phaseSel(phaseSel),
    .timeoutLimit(timeoutLimit), .dllStatus(dllStatus),
    .phyCtl0(phyCtl0), .phyCtl1(phyCtl1),
    .locked(locked), .timeoutErr(timeoutErr)
  );

  localparam logic [31:0] INIT = 32'h0010_1000;

  function automatic logic [31:0] expCtl1(bit ph);
    return ph ? 32'h86 : 32'h85;
  endfunction

  function automatic logic [31:0] expForced(logic [7:0] lv);
    return INIT | 32'h3 | ({24'h0, lv} << 24);
  endfunction

  function automatic logic [13:0] noLock();
    logic [13:0] s = 14'($urandom);
    if (s[2:0] == 3'b111) s[2:0] = 3'b011;
    return s;
  endfunction

  function automatic logic [13:0] withLock(logic [7:0] lv);
    logic [13:0] s = 14'($urandom);
    s[13:6] = lv;
    s[2:0]  = 3'b111;
    return s;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; start = 1'b0; dllStatus = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic runSeq(bit ph, int lim, int d, bit poke);
    logic [7:0] lv = 8'($urandom);
    bit outLock = 1'b0;
    logic [31:0] finalCtl;
    doReset();
    start = 1'b1; phaseSel = ph; timeoutLimit = 16'(lim); dllStatus = noLock();
    @(posedge clk); @(negedge clk); start = 1'b0;
    chk(phyCtl0 == INIT, "R2 ctl0 init", phyCtl0, INIT);
    chk(phyCtl1 == expCtl1(ph), "R2 ctl1 phase", phyCtl1, expCtl1(ph));
    @(posedge clk); @(negedge clk);
    chk(phyCtl0 == (INIT | 32'h2), "R3 on bit", phyCtl0, INIT | 32'h2);
    @(posedge clk); @(negedge clk);
    chk(phyCtl0 == (INIT | 32'h3), "R3 start bit", phyCtl0, INIT | 32'h3);
    for (int i = 0; i <= lim; i++) begin
      dllStatus = (i == d) ? withLock(lv) : noLock();
      start = poke && (i == 0);
      @(posedge clk); @(negedge clk);
      start = 1'b0;
      if (i == d) begin
        outLock = 1'b1;
        chk(locked && !timeoutErr, "R5 locked flag", {30'h0, locked, timeoutErr}, 32'h2);
        chk(phyCtl0 == expForced(lv), "R5 forced code", phyCtl0, expForced(lv));
        break;
      end else if (i == lim) begin
        chk(timeoutErr && !locked, "R6 timeout", {30'h0, locked, timeoutErr}, 32'h1);
        chk(phyCtl0 == (INIT | 32'h3), "R6 ctl0 at timeout", phyCtl0, INIT | 32'h3);
        break;
      end else begin
        chk(!locked && !timeoutErr && phyCtl0 == (INIT | 32'h3),
            "R4 R8 still waiting", phyCtl0, INIT | 32'h3);
      end
    end
    finalCtl = outLock ? expForced(lv) : (INIT | 32'h3);
    dllStatus = withLock(~lv);
    start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(phyCtl0 == finalCtl, "R7 R8 ctl0 frozen", phyCtl0, finalCtl);
    chk(locked == outLock && timeoutErr == !outLock, "R7 outcome sticky",
        {30'h0, locked, timeoutErr}, {30'h0, outLock, !outLock});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0;
    #1;
    chk(phyCtl0 == 0 && phyCtl1 == 0, "R1 ctl in reset", phyCtl0 | phyCtl1, 32'h0);
    chk(!locked && !timeoutErr, "R1 flags in reset", {30'h0, locked, timeoutErr}, 32'h0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(phyCtl0 == 0 && phyCtl1 == 0 && !locked && !timeoutErr, "R1 idle after reset",
        phyCtl0, 32'h0);
    runSeq(1'b0, 0, 0, 1'b0);
    runSeq(1'b1, 0, 1, 1'b0);
    runSeq(1'b0, 5, 5, 1'b1);
    runSeq(1'b1, 5, 6, 1'b1);
    runSeq(1'b1, 3, 0, 1'b1);
    for (int k = 0; k < 12; k++)
      runSeq(1'($urandom), int'($urandom_range(0, 15)), int'($urandom_range(0, 18)),
             1'($urandom));
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      testCnt++;
      failCnt++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end
endmodule